// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire station management bus (Clause 22 framing). It is programmed through a small synchronous register port that has two 32-bit words. The control word holds an enable bit and a 16-bit MDC divider. The command word starts one read or write frame to a register in an external PHY. After the frame, the same command word returns the result.

Software sets the enable bit and the divider first. It then writes the command word with the start flag set. The block generates MDC from its functional clock and serialises the frame on a split MDIO pin: a driven value, an output enable, and a sampled input. The start flag reads back as 1 while the frame runs and clears when the frame is over. For a read, the returned data and the acknowledge flag then sit in the command word.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the control word (address 0) reads 0x800000FF: status bit 31 = 1, enable bit 30 = 0, divider bits 15:0 = 0xFF. The command word (address 1) reads 0. `mdc` and `mdioOe` are 0.
- R2: Control bit 31 (idle) reads the inverse of the enable bit with one cycle of delay. It still reads 1 in the cycle after enable is written to 1, and reads 0 one cycle later.
- R3: While a frame runs, MDC has a period of d+1 clock cycles, where d is the divider value (a divider of 0 is taken as 1). MDC is high for floor(d/2)+1 cycles and low for the remaining cycles.
- R4: A frame is 64 MDC rising edges. The bits are 32 ones, then start 0,1, then opcode (write 0,1; read 1,0), then PHY address bits 20:16 and register address bits 25:21 of the command word, each MSB first. A write then sends turnaround 1,0 and data bits 15:0 MSB first. MDIO changes only while MDC is low and is stable while MDC is high.
- R5: On a read, the output enable is 1 for the first 46 bits and 0 from the first turnaround bit to the end. The 16 bits sampled at the last 16 rising edges, MSB first, replace command-word bits 15:0.
- R6: Command bit 29 (acknowledge) is 1 after a read if and only if MDIO was low at the rising edge of the second turnaround bit. It is cleared when a frame starts and stays 0 after a write.
- R7: Command bit 31 (go) is set by a command write with bit 31 = 1 (bit 30 = 1 selects write, 0 selects read). It reads 1 from the next cycle for 64(d+1)+floor(d/2)+1 cycles, then reads 0.
- R8: A command-word write is ignored in every field while go is 1, including in the cycle in which the frame ends.
- R9: A command write with bit 31 = 1 while enable is 0 is ignored: go stays 0, the fields keep their values, and MDC does not toggle.
- R10: Clearing enable during a frame aborts it one cycle later: go and acknowledge read 0, and `mdc` and `mdioOe` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Word select: 0 control, 1 command |
| busWrEn | input | 1 | Write strobe for the selected word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Sampled MDIO level |

## Verification
A software write to the command word can land in the very clock cycle in which the running frame finishes and go falls. The bench uses the cycle count of R7 to place a command write exactly on that edge. It expects the write to be lost: go stays 0 and the fields and read-back data of the finished frame are unchanged. A second collision is a write during the middle of a frame. That write must change neither the read-back fields nor the bits serialised on MDIO.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int IDX_W  = 8;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADR_W  = 5;

  typedef struct packed {
    logic             busy;
    logic             start;
    logic             drive;
    logic             rise;
    logic             stop;
    logic             sampleAck;
    logic             sampleData;
    logic             isRead;
    logic [IDX_W-1:0] bitIdx;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       st,
  input  logic              cmdWrite,
  input  logic [ADR_W-1:0]  cmdPhy,
  input  logic [ADR_W-1:0]  cmdReg,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAck
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 14;

  logic [FRAME_LEN-1:0] txBits;
  logic [FRAME_LEN-1:0] oeBits;
  logic [POS_W-1:0]     pos;

  // frame image, MSB goes out first
  always_comb begin
    txBits = {{PRE_LEN{1'b1}}, 2'b01, (cmdWrite ? 2'b01 : 2'b10), cmdPhy, cmdReg,
              (cmdWrite ? 2'b10 : 2'b11), (cmdWrite ? cmdData : {DATA_W{1'b1}})};
    oeBits = {{(FRAME_LEN-18){1'b1}}, {18{cmdWrite}}};
    pos    = POS_W'(FRAME_LEN - 1) - POS_W'(st.bitIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdc     <= 1'b0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
      rxData  <= '0;
      rxAck   <= 1'b0;
    end else if (st.stop) begin
      mdc     <= 1'b0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (st.start) begin
        rxData <= '0;
        rxAck  <= 1'b0;
      end
      if (st.drive) begin
        mdc     <= 1'b0;
        mdioOut <= txBits[pos];
        mdioOe  <= oeBits[pos];
      end
      if (st.rise) begin
        mdc <= 1'b1;
        if (st.sampleAck)  rxAck  <= !mdioIn;
        if (st.sampleData) rxData <= {rxData[DATA_W-2:0], mdioIn};
      end
    end
  end

  // R1: with no frame in progress the pins stay quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !st.busy |=> (!mdc && !mdioOe));

  // R5: read turnaround and data phase leave MDIO released
  p_release_ta_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.drive && st.isRead && (st.bitIdx >= IDX_W'(TA_POS))) |=> !mdioOe);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int               PRE_LEN   = 32,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxAck,
  output mdioStrobe_t       st,
  output logic              cmdWrite,
  output logic [ADR_W-1:0]  cmdPhy,
  output logic [ADR_W-1:0]  cmdReg,
  output logic [DATA_W-1:0] cmdData
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int ACK_POS   = PRE_LEN + 15;
  localparam int DATA_POS  = PRE_LEN + 16;

  logic             enable, idle, go, cmdAck;
  logic [DIV_W-1:0] div, divEff, half, cnt;
  logic [IDX_W-1:0] bitCnt;
  logic             active, atHalf, atEnd, finish, abort, accessOpen, ctrlWr;
  logic [3:0]       unusedBits;

  assign unusedBits = busWdata[29:26];

  always_comb begin
    divEff     = (div == '0) ? DIV_W'(1) : div;
    half       = divEff >> 1;
    active     = go && enable;
    atHalf     = active && (cnt == half);
    atEnd      = active && (cnt == divEff);
    finish     = atHalf && (bitCnt == IDX_W'(FRAME_LEN));
    abort      = go && !enable;
    ctrlWr     = busWrEn && !busAddr;
    accessOpen = busWrEn && busAddr && !go && !(busWdata[31] && !enable);

    st.busy       = go;
    st.start      = accessOpen && busWdata[31];
    st.drive      = atHalf && (bitCnt < IDX_W'(FRAME_LEN));
    st.rise       = atEnd;
    st.stop       = finish || abort;
    st.isRead     = !cmdWrite;
    st.sampleAck  = !cmdWrite && (bitCnt == IDX_W'(ACK_POS));
    st.sampleData = !cmdWrite && (bitCnt >= IDX_W'(DATA_POS));
    st.bitIdx     = bitCnt;

    busRdata = busAddr ? {go, cmdWrite, cmdAck, 3'b000, cmdReg, cmdPhy, cmdData}
                       : {idle, enable, 14'd0, div};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      idle     <= 1'b1;
      div      <= DIV_RESET;
      go       <= 1'b0;
      cmdWrite <= 1'b0;
      cmdAck   <= 1'b0;
      cmdPhy   <= '0;
      cmdReg   <= '0;
      cmdData  <= '0;
      cnt      <= '0;
      bitCnt   <= '0;
    end else begin
      idle <= !enable;
      if (ctrlWr) begin
        enable <= busWdata[30];
        div    <= busWdata[DIV_W-1:0];
      end
      if (accessOpen) begin
        cmdWrite <= busWdata[30];
        cmdReg   <= busWdata[25:21];
        cmdPhy   <= busWdata[20:16];
        cmdData  <= busWdata[DATA_W-1:0];
        if (busWdata[31]) begin
          go     <= 1'b1;
          cmdAck <= 1'b0;
          cnt    <= '0;
          bitCnt <= '0;
        end
      end else if (abort) begin
        go     <= 1'b0;
        cmdAck <= 1'b0;
      end else if (finish) begin
        go <= 1'b0;
        if (!cmdWrite) begin
          cmdData <= rxData;
          cmdAck  <= rxAck;
        end
      end else if (active) begin
        if (atEnd) begin
          cnt    <= '0;
          bitCnt <= bitCnt + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: a frame never starts while the controller is disabled
  p_go_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(go) |-> enable);

  // R8: busy command word is frozen against bus writes
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (go && busWrEn && busAddr) |=> ($stable(cmdPhy) && $stable(cmdReg) && $stable(cmdWrite)));

  // R7: go only falls after the full frame or on an abort
  p_go_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(go) |-> (($past(bitCnt) == IDX_W'(FRAME_LEN)) || !$past(enable)));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int               PRE_LEN   = 32,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'hFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t       st;
  logic              cmdWrite, rxAck;
  logic [ADR_W-1:0]  cmdPhy, cmdReg;
  logic [DATA_W-1:0] cmdData, rxData;

  mdio_ctrl #(.PRE_LEN(PRE_LEN), .DIV_RESET(DIV_RESET)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .rxData(rxData), .rxAck(rxAck),
    .st(st), .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdData(cmdData)
  );

  mdio_datapath #(.PRE_LEN(PRE_LEN)) uPath (
    .clk(clk), .rstN(rstN), .st(st), .cmdWrite(cmdWrite), .cmdPhy(cmdPhy),
    .cmdReg(cmdReg), .cmdData(cmdData), .mdioIn(mdioIn), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rxData(rxData), .rxAck(rxAck)
  );
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busAddr = 1'b0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  // capture of MDIO at every MDC rising edge
  int          capIdx = 0;
  logic [63:0] capVec = '0;
  logic [63:0] capOe = '0;
  int          stabErr = 0;
  logic        prevMdc = 1'b0;
  logic        lastOut = 1'b0;
  bit          phyOn = 0;
  logic [15:0] respData = '0;

  always #2 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = (phyOn && capIdx == 47) ? 1'b0 :
                  (phyOn && capIdx >= 48 && capIdx <= 63) ? respData[63-capIdx] : 1'b1;

  always @(negedge clk) begin
    if (mdc && !prevMdc) begin
      if (capIdx < 64) begin
        capVec[63-capIdx] = mdioOut;
        capOe[63-capIdx]  = mdioOe;
      end
      capIdx = capIdx + 1;
    end else if (mdc && prevMdc && mdioOut != lastOut) begin
      stabErr = stabErr + 1;
    end
    prevMdc = mdc;
    lastOut = mdioOut;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; the write lands on the next posedge
  task automatic busWrite(input logic addr, input logic [31:0] data);
    busAddr = addr; busWdata = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [31:0] data);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  function automatic logic [31:0] cmdWord(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {1'b1, wr, 4'b0000, rg, phy, d};
  endfunction

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  task automatic waitGoLow(output int n);
    logic [31:0] r;
    n = 0;
    busRead(1'b1, r);
    while (r[31] && n < 5000) begin
      n++;
      @(negedge clk);
      busRead(1'b1, r);
    end
  endtask

  task automatic t_reset;
    logic [31:0] r;
    busRead(1'b0, r);
    check(r == 32'h8000_00FF, "R1 control word", r, 32'h8000_00FF);
    busRead(1'b1, r);
    check(r == 32'h0, "R1 command word", r, 0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins", {mdc, mdioOe}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] r;
    busWrite(1'b0, 32'h4000_0003);
    busRead(1'b0, r);
    check(r == 32'hC000_0003, "R2 idle still set", r, 32'hC000_0003);
    @(negedge clk);
    busRead(1'b0, r);
    check(r == 32'h4000_0003, "R2 idle cleared", r, 32'h4000_0003);
  endtask

  task automatic t_write;
    logic [31:0] r;
    int n;
    capIdx = 0; stabErr = 0;
    busWrite(1'b1, cmdWord(1, 5'h11, 5'h0A, 16'hA53C));
    waitGoLow(n);
    check(n == 258, "R7 go duration d=3", n, 258);
    check(capIdx == 64, "R4 rising edge count", capIdx, 64);
    check(capVec == expFrame(1, 5'h11, 5'h0A, 16'hA53C), "R4 write frame bits", capVec, expFrame(1, 5'h11, 5'h0A, 16'hA53C));
    check(capOe == 64'hFFFF_FFFF_FFFF_FFFF, "R4 write drives all bits", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    check(stabErr == 0, "R4 mdio stable while mdc high", stabErr, 0);
    busRead(1'b1, r);
    check(r == 32'h4151_A53C, "R6 write leaves ack clear", r, 32'h4151_A53C);
  endtask

  task automatic t_readAck;
    logic [31:0] r;
    logic [63:0] e;
    int n;
    capIdx = 0; phyOn = 1; respData = 16'h1234;
    busWrite(1'b1, cmdWord(0, 5'h03, 5'h1F, 16'h0));
    waitGoLow(n);
    phyOn = 0;
    e = expFrame(0, 5'h03, 5'h1F, 16'h0);
    check(capVec[63:18] == e[63:18], "R4 read header bits", capVec[63:18], e[63:18]);
    check(capOe == 64'hFFFF_FFFF_FFFC_0000, "R5 release from turnaround", capOe, 64'hFFFF_FFFF_FFFC_0000);
    busRead(1'b1, r);
    check(r == 32'h23E3_1234, "R5 R6 read data with ack", r, 32'h23E3_1234);
  endtask

  task automatic t_readNoAck;
    logic [31:0] r;
    int n;
    capIdx = 0; phyOn = 0;
    busWrite(1'b1, cmdWord(0, 5'h07, 5'h02, 16'h0));
    waitGoLow(n);
    busRead(1'b1, r);
    check(r == 32'h0047_FFFF, "R6 no response, ack clear", r, 32'h0047_FFFF);
  endtask

  task automatic t_busyIgnore;
    logic [31:0] r;
    int n;
    capIdx = 0;
    busWrite(1'b1, cmdWord(1, 5'h15, 5'h06, 16'h5AA5));
    repeat (19) @(negedge clk);
    busWrite(1'b1, cmdWord(0, 5'h01, 5'h1C, 16'hFFFF));
    busRead(1'b1, r);
    check(r == 32'hC0D5_5AA5, "R8 mid-frame write ignored", r, 32'hC0D5_5AA5);
    repeat (258 - 1 - 20) @(negedge clk);
    busWrite(1'b1, cmdWord(0, 5'h01, 5'h1C, 16'hFFFF));
    busRead(1'b1, r);
    check(r == 32'h40D5_5AA5, "R8 write on finishing edge ignored", r, 32'h40D5_5AA5);
    check(capVec == expFrame(1, 5'h15, 5'h06, 16'h5AA5), "R8 frame unaffected", capVec, expFrame(1, 5'h15, 5'h06, 16'h5AA5));
  endtask

  task automatic measure(input int d);
    int h, l, n;
    capIdx = 0;
    busWrite(1'b0, 32'h4000_0000 | d);
    busWrite(1'b1, cmdWord(1, 5'h00, 5'h00, 16'h0));
    while (capIdx < 3) @(negedge clk);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    h = 0; l = 0;
    while (mdc) begin h++; @(negedge clk); end
    while (!mdc) begin l++; @(negedge clk); end
    begin
      int de = (d == 0) ? 1 : d;
      check(h == de/2 + 1, "R3 mdc high time", h, de/2 + 1);
      check(l == de - de/2, "R3 mdc low time", l, de - de/2);
    end
    waitGoLow(n);
  endtask

  task automatic t_disabled;
    logic [31:0] r;
    int toggles = 0;
    busWrite(1'b0, 32'h0000_0003);
    busWrite(1'b1, cmdWord(1, 5'h09, 5'h09, 16'h9999));
    busRead(1'b1, r);
    check(r == 32'h4000_0000, "R9 go while disabled ignored", r, 32'h4000_0000);
    repeat (20) begin @(negedge clk); if (mdc) toggles++; end
    check(toggles == 0, "R9 mdc quiet while disabled", toggles, 0);
    busRead(1'b0, r);
    check(r[31] == 1'b1, "R2 idle back after disable", r[31], 1);
  endtask

  task automatic t_abort;
    logic [31:0] r;
    busWrite(1'b0, 32'h4000_0003);
    phyOn = 1; respData = 16'hBEEF; capIdx = 0;
    busWrite(1'b1, cmdWord(0, 5'h02, 5'h04, 16'h0));
    repeat (60) @(negedge clk);
    busWrite(1'b0, 32'h0000_0003);
    busRead(1'b1, r);
    check(r[31] == 1'b1, "R10 go held one cycle", r[31], 1);
    @(negedge clk);
    busRead(1'b1, r);
    check(r[31:29] == 3'b000, "R10 go and ack cleared", r[31:29], 0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R10 pins released", {mdc, mdioOe}, 0);
    phyOn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_write();
    t_readAck();
    t_readNoAck();
    t_busyIgnore();
    measure(0);
    measure(4);
    t_disabled();
    t_abort();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule